// File: doc/BRIEF.md
# Bit-Addressed Serial I/O Transfer Engine

This block carries out the I/O-bus side of the bit-oriented instructions of a 16-bit processor. The instruction decoder hands it one command together with a base register value, a signed displacement, a bit count and a data word. The block then walks a 12-bit bit-address across the bus, one bit per clock. For each written bit it drives a serial data line and a one-clock write strobe. For each read bit it samples a serial input line.

The bit address comes from a base value that is twice the bit number. The lowest base bit cannot carry address information, because on the bus that line doubles as the data output.

- Single-bit commands (set, clear, test) add twice the displacement to the base.
- Multi-bit commands start at the least significant bit of the operand and step the address by one per bit.
- When the count is below 9, the operand is the high byte of the data word. Otherwise it is the whole word.

A one-clock `start` launches a command and a one-clock `done` marks its end. Read results appear on `rdata` and test results on `test_bit`.

Top module: `bitio_xfer`

## Requirements
- R1: After reset the block is idle: `done`, `wr_stb` and `sout` are 0, and `rdata` and `test_bit` are 0.
- R2: The bus address is bits 12:1 of the effective base. Bit 0 of the base has no effect on the address, and bits 15:13 are dropped.
- R3: For single-bit commands the effective base is `base` plus twice the sign-extended 8-bit `disp`. For multi-bit commands `disp` is not used.
- R4: The `cmd` codes are 0 set, 1 clear, 2 test, 3 multi-write and 4 multi-read. Set and clear each produce one strobe cycle, with `sout` at 1 or 0 respectively.
- R5: Test samples `sin` at the addressed bit and returns it on `test_bit`. It produces no strobe.
- R6: A multi-write sends operand bits starting at the least significant one. The address rises by one for each bit, and there is exactly one strobe per bit.
- R7: A `count` of 0 means 16 bits. Counts 1 to 15 are taken as they are.
- R8: When the count is below 9, the operand is the high byte. Write bit i comes from `wdata[8+i]` and read bit i lands in `rdata[8+i]`, and `rdata[7:0]` is 0.
- R9: When the count is 9 or more, bit i of the transfer maps to bit i of the word.
- R10: A multi-read returns 0 in every operand bit beyond the count.
- R11: `done` is high for exactly one clock. It rises N+1 clocks after the `start` edge, where N is the number of bits (1 for single-bit commands).
- R12: A `start` is ignored while a transfer is running, and also when `cmd` is above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock command launch |
| cmd | input | 3 | Command code |
| base | input | 16 | Base register value (twice the bit address) |
| disp | input | 8 | Signed displacement for single-bit commands |
| count | input | 4 | Bit count for multi-bit commands, 0 means 16 |
| wdata | input | 16 | Operand for multi-bit writes |
| sin | input | 1 | Serial input data line |
| bit_addr | output | 12 | Bus bit address |
| sout | output | 1 | Serial output data line |
| wr_stb | output | 1 | Write strobe, one clock per written bit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled multi-read result |
| test_bit | output | 1 | Result of the last test command |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of a running multi-bit transfer. Reaching it needs a command that lasts several clocks, plus a pulse timed inside that window. The bench launches a 16-bit write and pulses a set command at another address a few clocks later. It then checks that the bit memory holds only the first transfer's effect and that only one `done` appears.

Random commands cover the following:
- negative displacements;
- odd base values;
- address wrap at the top of the 12-bit space;
- every count on both sides of the byte/word boundary.

Directed cases cover the 8-bit write of 0xF1 and count 0.

// File: rtl/bitio_xfer.sv
module bitio_xfer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  cmd,
  input  logic [15:0] base,
  input  logic [7:0]  disp,
  input  logic [3:0]  count,
  input  logic [15:0] wdata,
  input  logic        sin,
  output logic [11:0] bit_addr,
  output logic        sout,
  output logic        wr_stb,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        test_bit
);
  localparam logic [2:0] OP_SET = 3'd0, OP_CLR = 3'd1, OP_TST = 3'd2,
                         OP_MWR = 3'd3, OP_MRD = 3'd4;

  logic [2:0]  op;
  logic [4:0]  left;
  logic [3:0]  pos;
  logic [15:0] wd;

  wire        single = cmd < OP_MWR;
  wire [15:0] off    = single ? {{7{disp[7]}}, disp, 1'b0} : 16'd0;
  wire [15:0] eff    = base + off;
  wire [4:0]  nbits  = single ? 5'd1 : (count == 4'd0 ? 5'd16 : {1'b0, count});

  assign wr_stb = busy & (op == OP_SET | op == OP_CLR | op == OP_MWR);
  assign sout   = busy & ((op == OP_SET) | (op == OP_MWR & wd[pos]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      op       <= OP_SET;
      left     <= 5'd0;
      pos      <= 4'd0;
      wd       <= 16'd0;
      bit_addr <= 12'd0;
      rdata    <= 16'd0;
      test_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start && cmd <= OP_MRD) begin
          busy     <= 1'b1;
          op       <= cmd;
          bit_addr <= eff[12:1];
          left     <= nbits;
          pos      <= (nbits < 5'd9) ? 4'd8 : 4'd0;
          wd       <= wdata;
          if (cmd == OP_MRD) rdata <= 16'd0;
        end
      end else begin
        if (op == OP_MRD) rdata[pos] <= sin;
        if (op == OP_TST) test_bit   <= sin;
        bit_addr <= bit_addr + 12'd1;
        pos      <= pos + 4'd1;
        left     <= left - 5'd1;
        if (left == 5'd1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n) (busy && left == 5'd1) |=> (done && !busy)); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (busy && left > 5'd1) |=> bit_addr == $past(bit_addr) + 12'd1); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(op)); // R12
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (left >= 5'd1 && left <= 5'd16)); // R7
  AST_NO_STB_READ: assert property (@(posedge clk) disable iff (!rst_n) (busy && (op == OP_TST || op == OP_MRD)) |-> !wr_stb); // R5
endmodule

// File: tb/bitio_xfer_tb.sv
module bitio_xfer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [15:0] base = 16'd0;
  logic [7:0] disp = 8'd0;
  logic [3:0] count = 4'd0;
  logic [15:0] wdata = 16'd0;
  logic sin;
  logic [11:0] bit_addr;
  logic sout, wr_stb, busy, done, test_bit;
  logic [15:0] rdata;

  logic [4095:0] mem;
  logic [4095:0] exp_mem;
  int errors = 0;
  int checks = 0;
  int stb_cnt = 0;
  int done_cnt = 0;

  always #2 clk = ~clk;

  assign sin = mem[bit_addr];

  bitio_xfer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .base(base), .disp(disp),
    .count(count), .wdata(wdata), .sin(sin), .bit_addr(bit_addr), .sout(sout),
    .wr_stb(wr_stb), .busy(busy), .done(done), .rdata(rdata), .test_bit(test_bit)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      mem[bit_addr] <= sout;
      stb_cnt <= stb_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int nb(input logic [2:0] c, input logic [3:0] k);
    if (c < 3) return 1;
    return (k == 0) ? 16 : int'(k);
  endfunction

  function automatic logic [11:0] first_addr(input logic [2:0] c, input logic [15:0] b, input logic [7:0] d);
    logic [15:0] e;
    e = b;
    if (c < 3) e = b + 16'($signed(d)) * 16'd2;
    return e[12:1];
  endfunction

  task automatic run(input logic [2:0] c, input logic [15:0] b, input logic [7:0] d,
                     input logic [3:0] k, input logic [15:0] w, input string tag);
    int n, cyc, lo;
    logic [11:0] a;
    logic [15:0] er;
    logic et;
    n = nb(c, k);
    a = first_addr(c, b, d);
    lo = (n < 9) ? 8 : 0;
    exp_mem = mem;
    er = rdata;
    et = test_bit;
    if (c == 4) er = 16'd0;
    for (int i = 0; i < n; i++) begin
      case (c)
        3'd0: exp_mem[a + 12'(i)] = 1'b1;
        3'd1: exp_mem[a + 12'(i)] = 1'b0;
        3'd2: et = mem[a];
        3'd3: exp_mem[a + 12'(i)] = w[lo + i];
        default: er[lo + i] = mem[a + 12'(i)];
      endcase
    end
    @(negedge clk);
    stb_cnt = 0;
    done_cnt = 0;
    cmd = c; base = b; disp = d; count = k; wdata = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == n + 1, {tag, " R11 latency"}, cyc, n + 1);
    @(negedge clk);
    chk(!done, {tag, " R11 pulse width"}, done, 0);
    chk(stb_cnt == ((c == 2 || c == 4) ? 0 : n), {tag, " R6 strobe count"}, stb_cnt, (c == 2 || c == 4) ? 0 : n);
    chk(mem == exp_mem, {tag, " R2 R3 R4 R6 memory image"}, 0, 0);
    if (c == 4) chk(rdata == er, {tag, " R8 R9 R10 read result"}, rdata, er);
    if (c == 2) chk(test_bit == et, {tag, " R5 test bit"}, test_bit, et);
  endtask

  initial begin
    int wd_cnt;
    wd_cnt = 0;
    fork
      begin
        while (wd_cnt < 150000) begin
          @(posedge clk);
          wd_cnt++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=less", wd_cnt);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) mem[i*32 +: 32] = $urandom;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !wr_stb && !sout && !busy, "R1 idle outputs", {done, wr_stb, sout, busy}, 0);
    chk(rdata == 16'd0 && !test_bit, "R1 results cleared", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 set/clear, R3 displacement equivalence
    run(3'd0, 16'h1EF4, 8'd0, 4'd0, 16'h0, "R4 set");
    chk(mem[12'hF7A] == 1'b1, "R3 set bit F7A", mem[12'hF7A], 1);
    run(3'd1, 16'h1EE0, 8'd10, 4'd0, 16'h0, "R3 clear via disp");
    chk(mem[12'hF7A] == 1'b0, "R3 disp reaches F7A", mem[12'hF7A], 0);
    run(3'd0, 16'h1EF5, 8'hFF, 4'd0, 16'h0, "R2 odd base negative disp");
    chk(mem[12'hF79] == 1'b1, "R2 bit0 ignored", mem[12'hF79], 1);
    run(3'd2, 16'h1EF2, 8'd0, 4'd0, 16'h0, "R5 test");
    // R8 byte form, 0xF1 example
    run(3'd3, 16'h1EF0, 8'd0, 4'd8, 16'hF100, "R8 F1 write");
    chk(mem[12'hF78 +: 8] == 8'hF1, "R8 F1 bits", mem[12'hF78 +: 8], 8'hF1);
    run(3'd4, 16'h1EF0, 8'd0, 4'd8, 16'h0, "R8 byte read");
    chk(rdata == 16'hF100, "R8 read back F1", rdata, 16'hF100);
    // R7 count zero
    run(3'd3, 16'h0100, 8'd5, 4'd0, 16'hA5C3, "R7 16-bit write");
    run(3'd4, 16'h0100, 8'd0, 4'd0, 16'h0, "R7 16-bit read");
    chk(rdata == 16'hA5C3, "R7 R9 word read back", rdata, 16'hA5C3);
    run(3'd4, 16'h0100, 8'd0, 4'd5, 16'h0, "R10 short read");
    chk(rdata == 16'h0300, "R10 R8 5-bit read", rdata, 16'h0300);
    run(3'd4, 16'h0100, 8'd0, 4'd9, 16'h0, "R9 nine-bit read");
    chk(rdata == 16'h01C3, "R9 R10 9-bit read", rdata, 16'h01C3);
    // address wrap
    run(3'd3, 16'h1FFC, 8'd0, 4'd4, 16'h0F00, "R6 wrap write");
    // R12 illegal command ignored
    @(negedge clk);
    done_cnt = 0; cmd = 3'd6; start = 1'b1; base = 16'h0200;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(done_cnt == 0 && !busy, "R12 illegal cmd ignored", done_cnt, 0);
    // R12 start while busy
    exp_mem = mem;
    for (int i = 0; i < 16; i++) exp_mem[12'h300 + 12'(i)] = 1'(16'h5A5A >> i);
    done_cnt = 0;
    cmd = 3'd3; base = 16'h0600; count = 4'd0; wdata = 16'h5A5A; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    cmd = 3'd0; base = 16'h0800; disp = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(mem == exp_mem, "R12 busy start no effect", 0, 0);
    chk(done_cnt == 1, "R12 single done", done_cnt, 1);
    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [2:0] rc;
      rc = 3'($urandom_range(0, 4));
      run(rc, 16'($urandom), 8'($urandom), 4'($urandom), 16'($urandom), "random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule